// File: doc/BRIEF.md
# Fuse ROM Read Controller

This block lets software read a one-time-programmable fuse array through a small word-addressed register port. Software first writes a configuration word that holds two timing counts: how long the array address must be held before the read strobe rises, and how long the strobe stays high. It then writes a control word that holds a start byte address, a transfer length minus one and a read-enable bit.

When the read starts, the controller walks through the requested bytes one after another. For each byte it drives the array address, waits out the setup count, pulses the strobe for the programmed width and captures the array's byte output on the last strobe cycle. Captured bytes are packed into a bank of eight 32-bit data words. A read-done flag in the status word tells software when the bank is complete. The array holds 1024 bytes (8192 bits), and each access moves at most one 32-byte chunk.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: The port selects words by index: 0 is control, 1 is configuration, 2 is status, and 3 to 10 are data words 0 to 7. Any other index reads zero. The configuration word reads back all 32 written bits. Writes to status or data words have no effect. Status bit 1 (write done) always reads 0.
- R2: Control word fields are: start byte address in bits 30:21, length minus one in bits 20:16, program enable in bit 15, write enable in bit 1 and read enable in bit 0. A control write while idle stores all 32 bits. Only a written read enable of 1 starts an access, and read enable clears itself when the access ends.
- R3: Before each byte, the byte address (start address plus byte number) is presented with the strobe low for read-adjust + 1 cycles. Read adjust is configuration bits 23:20. The address stays constant while the strobe is high.
- R4: The strobe stays high for read-strobe + 4 cycles, where read strobe is configuration bits 19:16. Each byte access therefore takes read-adjust + read-strobe + 5 cycles. Both counts are taken from the configuration when the access starts.
- R5: The array byte present on the last strobe cycle of byte k is stored in data word k/4 at bits 8*(k%4)+7 down to 8*(k%4), which is little-endian packing.
- R6: Starting an access clears all eight data words, so bytes past the requested length read zero.
- R7: A byte whose address (start plus byte number) is 1024 or more is stored as zero, and the strobe is not raised for it.
- R8: Starting an access clears read done (status bit 0). Read done is set in the cycle after the last byte is captured.
- R9: A control write that arrives while an access is running is ignored. The running access completes with its original address and length.
- R10: After reset, every register reads zero and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fuse_addr | output | 10 | Fuse array byte address |
| fuse_strobe | output | 1 | Fuse array read strobe |
| fuse_rdata | input | 8 | Fuse array byte output |

## Verification
The bench reads all 32 chunks of the array with the shortest timing. This shows that every address is formed correctly and every byte lands in its own lane. It then repeats reads at several setup and strobe counts, up to the largest of each, and measures every strobe pulse and every gap between pulses. That separates an off-by-one in either count from a data error. Short and partial-word lengths, a chunk that runs past the array end, and a second request sent in the middle of an access each test a distinct rule: zero fill of the bank, suppression of out-of-range bytes, and rejection of requests while busy.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_CFG    = 1;
  localparam int unsigned IDX_STAT   = 2;
  localparam int unsigned IDX_DATA0  = 3;

  localparam int unsigned CTRL_ADDR_LSB = 21;
  localparam int unsigned CTRL_LEN_LSB  = 16;
  localparam int unsigned CTRL_RDEN_BIT = 0;
  localparam int unsigned CFG_ADJ_LSB   = 20;
  localparam int unsigned CFG_STB_LSB   = 16;
  localparam int unsigned TIM_W         = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned FUSE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [TIM_W-1:0]  adj_cnt,
  input  logic [TIM_W-1:0]  stb_cnt,
  input  logic [7:0]        arr_byte,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_strobe,
  output logic              busy,
  output logic              done,
  output logic              cap_vld,
  output logic [LEN_W-1:0]  cap_idx,
  output logic [7:0]        cap_byte
);
  localparam int unsigned TMR_W = TIM_W + 1;

  seq_state_t        st_q, st_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [LEN_W-1:0]  k_q, k_d;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [TIM_W-1:0]  adj_q, stb_q;
  logic              load_en;
  logic [ADDR_W:0]   full_addr;
  logic              in_range;

  assign full_addr  = {1'b0, base_q} + {{(ADDR_W+1-LEN_W){1'b0}}, k_q};
  assign in_range   = (full_addr < (ADDR_W+1)'(FUSE_BYTES));
  assign arr_addr   = full_addr[ADDR_W-1:0];
  assign arr_strobe = (st_q == ST_STROBE) && in_range;
  assign busy       = (st_q != ST_IDLE);
  assign cap_vld    = (st_q == ST_STROBE) && (tmr_q == '0);
  assign cap_idx    = k_q;
  assign cap_byte   = in_range ? arr_byte : 8'h00;
  assign done       = cap_vld && (k_q == len_q);
  assign load_en    = (st_q == ST_IDLE) && start;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    k_d   = k_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_SETUP;
          tmr_d = {1'b0, adj_cnt};
          k_d   = '0;
        end
      end
      ST_SETUP: begin
        if (tmr_q == '0) begin
          st_d  = ST_STROBE;
          tmr_d = {1'b0, stb_q} + TMR_W'(3);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_STROBE: begin
        if (tmr_q == '0) begin
          if (k_q == len_q) begin
            st_d = ST_IDLE;
          end else begin
            st_d  = ST_SETUP;
            tmr_d = {1'b0, adj_q};
            k_d   = k_q + 1'b1;
          end
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      k_q   <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      k_q   <= k_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      adj_q  <= '0;
      stb_q  <= '0;
    end else if (load_en) begin
      base_q <= start_addr;
      len_q  <= start_len;
      adj_q  <= adj_cnt;
      stb_q  <= stb_cnt;
    end
  end
endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              cap_vld,
  input  logic [LEN_W-1:0]  cap_idx,
  input  logic [7:0]        cap_byte,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic [LEN_W-1:0]  start_len,
  output logic [TIM_W-1:0]  adj_cnt,
  output logic [TIM_W-1:0]  stb_cnt,
  output logic              rd_done,
  output logic [31:0]       ctrl_word
);
  localparam int unsigned BANK_BYTES = 2 ** LEN_W;
  localparam int unsigned NWORDS     = BANK_BYTES / 4;

  logic [31:0] ctrl_q, ctrl_d;
  logic [31:0] cfg_q, cfg_d;
  logic        done_q, done_d;
  logic [31:0] data_q [NWORDS];
  logic        ctrl_wr, cfg_wr;

  assign ctrl_wr    = bus_we && (bus_idx == IDX_W'(IDX_CTRL)) && !seq_busy;
  assign cfg_wr     = bus_we && (bus_idx == IDX_W'(IDX_CFG));
  assign start      = ctrl_wr && bus_wdata[CTRL_RDEN_BIT];
  assign start_addr = bus_wdata[CTRL_ADDR_LSB +: ADDR_W];
  assign start_len  = bus_wdata[CTRL_LEN_LSB +: LEN_W];
  assign adj_cnt    = cfg_q[CFG_ADJ_LSB +: TIM_W];
  assign stb_cnt    = cfg_q[CFG_STB_LSB +: TIM_W];
  assign rd_done    = done_q;
  assign ctrl_word  = ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata;
    else if (seq_done) ctrl_d[CTRL_RDEN_BIT] = 1'b0;
    cfg_d  = cfg_wr ? bus_wdata : cfg_q;
    done_d = done_q;
    if (start) done_d = 1'b0;
    else if (seq_done) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cfg_q  <= cfg_d;
      done_q <= done_d;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [31:0] word_d;
    logic        word_en;
    always_comb begin
      word_d  = data_q[w];
      word_en = 1'b0;
      if (start) begin
        word_d  = '0;
        word_en = 1'b1;
      end else if (cap_vld && (cap_idx[LEN_W-1:2] == (LEN_W-2)'(w))) begin
        word_d[8*cap_idx[1:0] +: 8] = cap_byte;
        word_en = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[w] <= '0;
      else if (word_en) data_q[w] <= word_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_idx == IDX_W'(IDX_CTRL)) bus_rdata = ctrl_q;
    else if (bus_idx == IDX_W'(IDX_CFG)) bus_rdata = cfg_q;
    else if (bus_idx == IDX_W'(IDX_STAT)) bus_rdata = {31'b0, done_q};
    else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (bus_idx == IDX_W'(IDX_DATA0 + w)) bus_rdata = data_q[w];
      end
    end
  end
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned FUSE_BYTES = 1024,
  parameter int unsigned IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic              fuse_strobe,
  input  logic [7:0]        fuse_rdata
);
  logic              rst_meta_q, rst_sync_n;
  logic              start, seq_busy, seq_done, cap_vld, rd_done;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  start_len, cap_idx;
  logic [TIM_W-1:0]  adj_cnt, stb_cnt;
  logic [7:0]        cap_byte;
  logic [31:0]       ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  fuse_rd_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_we(reg_we), .bus_idx(reg_idx), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .seq_busy(seq_busy), .seq_done(seq_done),
    .cap_vld(cap_vld), .cap_idx(cap_idx), .cap_byte(cap_byte),
    .start(start), .start_addr(start_addr), .start_len(start_len),
    .adj_cnt(adj_cnt), .stb_cnt(stb_cnt), .rd_done(rd_done), .ctrl_word(ctrl_word)
  );

  fuse_rd_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FUSE_BYTES(FUSE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .start(start), .start_addr(start_addr), .start_len(start_len),
    .adj_cnt(adj_cnt), .stb_cnt(stb_cnt), .arr_byte(fuse_rdata),
    .arr_addr(fuse_addr), .arr_strobe(fuse_strobe),
    .busy(seq_busy), .done(seq_done),
    .cap_vld(cap_vld), .cap_idx(cap_idx), .cap_byte(cap_byte)
  );
endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
module fuse_rd_ctrl_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [ADDR_W-1:0] fuse_addr,
  input logic              fuse_strobe,
  input logic              busy,
  input logic              done,
  input logic              start,
  input logic              rd_done,
  input logic [31:0]       ctrl_word
);
  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fuse_strobe);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr));

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rd_done);

  // R8
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!rd_done && busy));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_idx == '0) |=> $stable(ctrl_word[30:16]));

  // R2
  rden_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ctrl_word[0]);
endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_we(reg_we), .reg_idx(reg_idx),
  .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe), .busy(seq_busy),
  .done(seq_done), .start(start), .rd_done(rd_done), .ctrl_word(ctrl_word)
);

// File: tb/fuse_rd_ctrl_bench.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_bench;
  logic        clk, rst_n, reg_we;
  logic [3:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic [9:0]  fuse_addr;
  logic        fuse_strobe;
  logic [7:0]  fuse_rdata;

  int checks = 0, errors = 0;
  logic        mon_on = 0, have_prev = 0;
  int          run = 0, gap = 0, nbyte = 0, exp_adj = 0, exp_stb = 0;
  logic [9:0]  exp_base = 0, last_addr = 0;

  fuse_rd_ctrl u_fuse_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe), .fuse_rdata(fuse_rdata)
  );

  function automatic logic [7:0] fval(input int a);
    fval = 8'((a * 29) ^ (a >> 2) ^ 32'h5A);
  endfunction

  assign fuse_rdata = fuse_strobe ? fval(int'(fuse_addr)) : 8'h00;

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (fuse_strobe) begin
        if (run == 0) begin
          chk("R3 addr", 32'(fuse_addr), 32'(exp_base + 10'(nbyte)));
          if (have_prev) chk("R3 setup gap", gap, exp_adj + 1);
        end else begin
          chk("R3 addr hold", 32'(fuse_addr), 32'(last_addr));
        end
        last_addr = fuse_addr;
        run++;
      end else if (run > 0) begin
        chk("R4 strobe width", run, exp_stb + 4);
        nbyte++;
        have_prev = 1;
        run = 0;
        gap = 1;
      end else if (have_prev) begin
        gap++;
      end
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = 4'(idx);
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int n = 0;
    do begin rd(2, s); n++; end while (!s[0] && n < 5000);
    chk(req, s, 32'h1);
  endtask

  task automatic do_read(input int base, input int len, input int adj, input int stb);
    logic [31:0] v, e;
    wr(1, (32'(adj) << 20) | (32'(stb) << 16));
    exp_base = 10'(base); exp_adj = adj; exp_stb = stb;
    nbyte = 0; have_prev = 0; run = 0; mon_on = 1;
    wr(0, (32'(base) << 21) | (32'(len) << 16) | 32'h1);
    wait_done("R8 done");
    mon_on = 0;
    rd(0, v);
    chk("R2 rden self clear", 32'(v[0]), 0);
    for (int w = 0; w < 8; w++) begin
      e = 0;
      for (int j = 0; j < 4; j++) begin
        int k = 4 * w + j;
        if (k <= len && base + k < 1024) e[8*j +: 8] = fval(base + k);
      end
      rd(3 + w, v);
      chk("R5/R6/R7 data", v, e);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    reg_we = 0; reg_idx = 0; reg_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    for (int i = 0; i < 11; i++) begin rd(i, v); chk("R10 reset reg", v, 0); end
    chk("R10 strobe low", 32'(fuse_strobe), 0);
    // R1 map and read-only words
    wr(1, 32'hA5A5F00F); rd(1, v); chk("R1 cfg readback", v, 32'hA5A5F00F);
    wr(2, 32'hFFFFFFFF); rd(2, v); chk("R1 status write ignored", v, 0);
    wr(4, 32'h12345678); rd(4, v); chk("R1 data write ignored", v, 0);
    rd(12, v); chk("R1 unmapped index", v, 0);
    // R2 fields stored without starting
    wr(0, 32'h7FDF8002); rd(0, v); chk("R2 ctrl store", v, 32'h7FDF8002);
    rd(2, v); chk("R2 no start without rden", v, 0);
    // full array sweep, shortest timing
    for (int c = 0; c < 32; c++) do_read(c * 32, 31, 0, 0);
    // timing sweep
    do_read(100, 31, 1, 0);
    do_read(517, 31, 0, 3);
    do_read(250, 31, 2, 5);
    do_read(61, 31, 7, 1);
    do_read(333, 31, 15, 15);
    // R6 short lengths
    do_read(3, 0, 1, 1);
    do_read(200, 5, 0, 2);
    // R7 past end of array
    do_read(1000, 31, 1, 1);
    do_read(1023, 3, 0, 0);
    // R9 request while busy
    wr(1, (32'd15 << 20) | (32'd15 << 16));
    exp_base = 10'd40; exp_adj = 15; exp_stb = 15;
    nbyte = 0; have_prev = 0; run = 0; mon_on = 1;
    wr(0, (32'd40 << 21) | (32'd31 << 16) | 32'h1);
    repeat (10) @(negedge clk);
    wr(0, (32'd700 << 21) | (32'd2 << 16) | 32'h1);
    rd(0, v); chk("R9 ctrl unchanged", v, (32'd40 << 21) | (32'd31 << 16) | 32'h1);
    wait_done("R9 done");
    mon_on = 0;
    for (int w = 0; w < 8; w++) begin
      logic [31:0] e;
      for (int j = 0; j < 4; j++) e[8*j +: 8] = fval(40 + 4 * w + j);
      rd(3 + w, v);
      chk("R9 original data", v, e);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule